// File: doc/BRIEF.md
# Two-Access Delayed Cartridge RAM Writer

This block lets a host that can only issue read-style accesses on a cartridge bus store bytes into a small cartridge RAM. The bus carries address lines, a valid strobe and a marker for the final cycle of an instruction. It carries no processor clock. Every byte value is therefore encoded in the low address bits of an access.

A write takes two steps. First, a final-cycle access into the data page captures the low address byte as the pending value. Second, a final-cycle access into the RAM page, made within a programmable number of cycles, stores that value at the addressed location. The gap between the two steps is measured by a local free-running cycle counter. The host programs the window length and a write-enable bit through a control page, using the same offset encoding.

Address map with default parameters:

| Page | Range | Use |
|------|-------|-----|
| Data | 0xF000–0xF0FF | First step |
| Control | 0xF100–0xF1FF | Control load |
| RAM | 0xF800–0xF8FF | Reads and second step |

Top module: `cart_delayed_ram_writer`

## Requirements
- R1: After reset the control byte is zero, so writing is disabled and the delay is 0. No byte is pending, every RAM location reads 0x00, and data_oe is low when the bus is idle.
- R2: A final-cycle access (bus_valid=1, bus_last=1) to the control page (0xF1xx) loads the low address byte as the control byte. Bits 7:5 are the delay D and bit 1 is the write enable. The load also drops any pending byte.
- R3: When writing is enabled and D is nonzero, a final-cycle access to the data page (0xF0xx) captures the low address byte as the pending value. An access to that page with bus_last=0 captures nothing.
- R4: A final-cycle access to the RAM page (0xF8xx) while a byte is pending, made g cycles after the capture with 1 <= g <= D, stores the pending byte at the low address byte. During that cycle data_oe stays low.
- R5: With D=5, gaps of 4 and 5 cycles both commit. With D=7, a gap of 7 commits.
- R6: When no commit arrives by gap D, the pending byte is discarded, and a later RAM-page access writes nothing. With D=0, nothing is ever captured.
- R7: With the write enable clear, data-page accesses are ignored and RAM is never written.
- R8: A data-page capture made while a byte is still pending replaces the value and restarts the gap count from that capture.
- R9: Any valid RAM-page access that does not commit drives data_oe high in the same cycle, with data_out equal to the stored byte. Outside the RAM page data_oe is low.
- R10: A commit consumes the pending byte, so a second RAM-page access without a new capture writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock at the nominal processor rate |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | The address bus holds a valid access this cycle |
| bus_last | input | 1 | This access is the final cycle of the instruction |
| bus_addr | input | ADDR_W | Access address (16 bits by default) |
| data_out | output | 8 | Byte read from RAM |
| data_oe | output | 1 | Data bus drive enable |

## Verification
The assertions assume that bus_last is only high together with bus_valid. They also assume that the three page codes are distinct, so a single access can never be both a capture and a commit. The stimulus drives each access for exactly one cycle, with pages taken only from the fixed map above. It reads RAM with bus_last low, so a read can never consume a pending byte by accident. It sets the gap by inserting counted idle cycles, with bus_valid low, between the capture and the commit.

// File: rtl/cart_delayed_ram_writer.sv
module cart_delayed_ram_writer #(
  parameter int ADDR_W    = 16,
  parameter int DLY_W     = 3,
  parameter int WE_BIT    = 1,
  parameter int DATA_PAGE = 'hF0,
  parameter int CTRL_PAGE = 'hF1,
  parameter int RAM_PAGE  = 'hF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_last,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        data_out,
  output logic              data_oe
);
  localparam int PAGE_W = ADDR_W - 8;
  localparam int CNT_W  = DLY_W + 1;
  localparam int DEPTH  = 256;

  logic [7:0]       ctrl, held;
  logic             pending;
  logic [CNT_W-1:0] free_cnt, stamp;
  logic [7:0]       mem [DEPTH];

  wire [PAGE_W-1:0] page   = bus_addr[ADDR_W-1:8];
  wire [7:0]        off    = bus_addr[7:0];
  wire              wr_en  = ctrl[WE_BIT];
  wire [CNT_W-1:0]  dly    = {1'b0, ctrl[7:8-DLY_W]};
  wire              fin    = bus_valid && bus_last;
  wire              ctrl_ld = fin && page == PAGE_W'(CTRL_PAGE);
  wire              data_ph = fin && page == PAGE_W'(DATA_PAGE) && wr_en && dly != '0;
  wire              ram_hit = bus_valid && page == PAGE_W'(RAM_PAGE);
  wire [CNT_W-1:0]  gap    = free_cnt - stamp;
  wire              commit = fin && ram_hit && pending && wr_en && gap <= dly;

  assign data_oe  = ram_hit && !commit;
  assign data_out = data_oe ? mem[off] : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_cnt <= '0;
      stamp    <= '0;
      ctrl     <= 8'h00;
      held     <= 8'h00;
      pending  <= 1'b0;
    end else begin
      free_cnt <= free_cnt + 1'b1;
      if (ctrl_ld) begin
        ctrl    <= off;
        pending <= 1'b0;
      end else if (data_ph) begin
        held    <= off;
        stamp   <= free_cnt;
        pending <= 1'b1;
      end else if (commit || (pending && gap >= dly)) begin
        pending <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (commit) begin
      mem[off] <= held;
    end
  end

  AST_PEND_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> (gap >= 1 && gap <= dly)) else $error("pending outside window"); // R6
  AST_CAPTURE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    data_ph |=> (pending && held == $past(off))) else $error("capture lost"); // R3
  AST_COMMIT_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !pending) else $error("pending kept after commit"); // R10
  AST_WE_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> !pending) else $error("pending while disabled"); // R7
  AST_OE_RAM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (bus_valid && page == PAGE_W'(RAM_PAGE))) else $error("stray drive"); // R9
  AST_CTRL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_ld |=> (!pending && ctrl == $past(off))) else $error("ctrl load"); // R2
endmodule

// File: tb/cart_delayed_ram_writer_tb.sv
module cart_delayed_ram_writer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_last = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  data_out;
  logic        data_oe;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  cart_delayed_ram_writer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_last(bus_last),
    .bus_addr(bus_addr), .data_out(data_out), .data_oe(data_oe));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] a, input logic last, input logic valid);
    @(negedge clk);
    bus_addr = a; bus_last = last; bus_valid = valid;
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(16'h0000, 1'b0, 1'b0);
  endtask

  task automatic rd(input logic [7:0] idx, input logic [7:0] exp, input string req);
    step({8'hF8, idx}, 1'b0, 1'b1);
    chk(data_oe === 1'b1, req, data_oe, 1);
    chk(data_out === exp, req, data_out, exp);
  endtask

  task automatic ctl(input logic [7:0] v);
    step({8'hF1, v}, 1'b1, 1'b1);
  endtask

  // capture byte v, wait for gap g, then issue a final-cycle RAM-page access at idx
  task automatic two_step(input logic [7:0] v, input int g, input logic [7:0] idx,
                          input bit expect_commit, input string req);
    step({8'hF0, v}, 1'b1, 1'b1);
    idle(g - 1);
    step({8'hF8, idx}, 1'b1, 1'b1);
    chk(data_oe === !expect_commit, req, data_oe, !expect_commit);
  endtask

  task automatic t_reset;
    idle(1);
    chk(data_oe === 1'b0, "R1", data_oe, 0);
    rd(8'h05, 8'h00, "R1");
    two_step(8'hAA, 2, 8'h05, 1'b0, "R7");
    rd(8'h05, 8'h00, "R7");
  endtask

  task automatic t_mid;
    ctl(8'hA2);
    two_step(8'h5A, 5, 8'h10, 1'b1, "R4");
    rd(8'h10, 8'h5A, "R5");
    two_step(8'h3C, 4, 8'h11, 1'b1, "R5");
    rd(8'h11, 8'h3C, "R5");
    two_step(8'h99, 1, 8'h13, 1'b1, "R4");
    rd(8'h13, 8'h99, "R4");
  endtask

  task automatic t_expire;
    two_step(8'h44, 6, 8'h12, 1'b0, "R6");
    rd(8'h12, 8'h00, "R6");
    step(16'hF812, 1'b1, 1'b1);
    rd(8'h12, 8'h00, "R6");
  endtask

  task automatic t_not_last;
    step(16'hF066, 1'b0, 1'b1);
    idle(1);
    step(16'hF814, 1'b1, 1'b1);
    chk(data_oe === 1'b1, "R3", data_oe, 1);
    rd(8'h14, 8'h00, "R3");
  endtask

  task automatic t_replace;
    step(16'hF011, 1'b1, 1'b1);
    idle(1);
    two_step(8'h22, 5, 8'h15, 1'b1, "R8");
    rd(8'h15, 8'h22, "R8");
  endtask

  task automatic t_once;
    two_step(8'h77, 2, 8'h20, 1'b1, "R10");
    step(16'hF821, 1'b1, 1'b1);
    chk(data_oe === 1'b1, "R10", data_oe, 1);
    rd(8'h21, 8'h00, "R10");
    rd(8'h20, 8'h77, "R10");
  endtask

  task automatic t_ctrl_drop;
    step(16'hF0BB, 1'b1, 1'b1);
    ctl(8'hA2);
    step(16'hF822, 1'b1, 1'b1);
    chk(data_oe === 1'b1, "R2", data_oe, 1);
    rd(8'h22, 8'h00, "R2");
  endtask

  task automatic t_edges;
    ctl(8'h02);
    two_step(8'h55, 1, 8'h30, 1'b0, "R6");
    rd(8'h30, 8'h00, "R6");
    ctl(8'hE2);
    two_step(8'h71, 7, 8'h31, 1'b1, "R5");
    rd(8'h31, 8'h71, "R5");
    two_step(8'h72, 8, 8'h32, 1'b0, "R6");
    rd(8'h32, 8'h00, "R6");
    ctl(8'hE0);
    two_step(8'h73, 2, 8'h33, 1'b0, "R7");
    rd(8'h33, 8'h00, "R7");
    step(16'hF010, 1'b0, 1'b1);
    chk(data_oe === 1'b0, "R9", data_oe, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_mid;
    t_expire;
    t_not_last;
    t_replace;
    t_once;
    t_ctrl_drop;
    t_edges;
    idle(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule